// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the completion pulses of a set of DMA channels into one interrupt line. Each channel owns one bit in a latched status register. Software clears a bit by writing a 1 to it. A separate enable register selects which status bits may raise the interrupt. A read-only pending view shows status masked by enable, and the interrupt output is high whenever that view is nonzero. Software can mask every source by writing zero to the enable register, and the latched status is kept when it does so.

The block also holds a one-bit address-mode control that selects 32-bit addressing, and it decodes the register bus address into the channel it targets. Channels come in pairs. The even channel of a pair receives and the odd channel transmits. Each pair occupies a 0x40-byte window, and the transmit half begins 0x18 bytes into that window. The channels' own data movement lives outside this block.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous reset, the status, enable and address-mode registers, the interrupt output and the read data are all zero.
- R2: A one-cycle pulse on done_pulse[n] sets status bit n at the next clock edge, whatever the state of enable bit n.
- R3: A write to offset 0x080000 clears every status bit whose write-data bit is 1 and leaves the other status bits unchanged. Writing 0xFFFFFFFF clears all of them.
- R4: When a done pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A read of offset 0x080004 returns status AND enable, with bit n belonging to channel n. Writes to that offset change neither status nor enable.
- R6: The irq output is high exactly when status AND enable is nonzero. It changes at the same clock edge as the registers it depends on.
- R7: A write to offset 0x080008 loads the enable register, which reads back at the same offset. Writing 0 drops irq and keeps the latched status bits.
- R8: The address-mode register at offset 0x34 stores write-data bit 0 and drives addr32_mode. It reads back in bit 0, and its upper bits read as zero.
- R9: A read of any offset other than 0x34, 0x080000, 0x080004 or 0x080008 returns zero.
- R10: Read data appears on bus_rdata one cycle after bus_rd is sampled high and holds its value until the next read.
- R11: For an address with pair index k = addr[ADDR_W-1:6] and window offset o = addr[5:0], the decoder behaves as follows:
  - For o < 0x18, it selects receive channel 2k with local offset o.
  - For 0x18 <= o < 0x30, it selects transmit channel 2k+1 with local offset o-0x18.
  - For o >= 0x30, or when the selected channel number is NCH or more, ch_hit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| done_pulse | input | NCH | One-cycle completion pulse per channel |
| irq | output | 1 | Shared interrupt, high while any pending bit is set |
| addr32_mode | output | 1 | 32-bit addressing select |
| ch_hit | output | 1 | bus_addr falls in a channel register window |
| ch_idx | output | CIW | Channel targeted by bus_addr |
| ch_is_tx | output | 1 | Targeted channel is the transmit half |
| ch_loff | output | 5 | Byte offset inside the channel window |

## Verification
The bench sweeps every status pattern of a six-channel configuration against a spread of enable masks. A design that reported raw status as pending, or that raised irq from a masked bit, fails there. It drives a done pulse and a clearing write into the same bit in the same cycle, which catches a design where the clear wins. It also checks that a zero enable leaves the status intact, so a design that cleared status on masking is caught. It walks every word address of all pairs plus one pair beyond the last. A mistake in the 0x18 transmit split, in the 0x30 hole or in the upper channel bound shows up as a wrong hit, index or local offset.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;
  localparam logic [31:0] OFS_ADDRMODE = 32'h0000_0034;
  localparam logic [31:0] OFS_STATUS   = 32'h0008_0000;
  localparam logic [31:0] OFS_PENDING  = 32'h0008_0004;
  localparam logic [31:0] OFS_ENABLE   = 32'h0008_0008;
  localparam int unsigned PAIR_SHIFT   = 6;
  localparam int unsigned TX_START     = 'h18;
  localparam int unsigned WIN_END      = 'h30;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_STAT, SEL_PEND, SEL_EN
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic           en_we,
  input  logic [NCH-1:0] en_wdata,
  output logic [NCH-1:0] stat_o,
  output logic [NCH-1:0] en_o,
  output logic           irq_o
);
  logic [NCH-1:0] stat_q, stat_n, en_q, en_n;
  logic           irq_q;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_bit
      assign stat_n[gi] = (stat_q[gi] & ~clr_i[gi]) | set_i[gi];
    end
  endgenerate

  assign en_n = en_we ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      en_q   <= en_n;
      irq_q  <= |(stat_n & en_n);
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chk
      a_r2_done_sets: assert property (@(posedge clk) disable iff (rst)
        set_i[gi] |=> stat_q[gi]);
      a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (set_i[gi] && clr_i[gi]) |=> stat_q[gi]);
      a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i[gi] && !set_i[gi]) |=> !stat_q[gi]);
    end
  endgenerate

  a_r7_mask_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  a_r6_irq_tracks_pending: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(stat_q & en_q));
endmodule

// File: rtl/dma_irq_chan_decode.sv
module dma_irq_chan_decode #(
  parameter int unsigned NCH    = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CIW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [CIW-1:0]    idx_o,
  output logic              tx_o,
  output logic [4:0]        loff_o
);
  import dma_irq_agg_pkg::*;
  localparam int unsigned PW = ADDR_W - PAIR_SHIFT;

  logic [PW-1:0] pair;
  logic [5:0]    wofs;
  logic          in_win;
  logic [PW:0]   chan_full;

  always_comb begin
    pair      = addr_i[ADDR_W-1:PAIR_SHIFT];
    wofs      = addr_i[PAIR_SHIFT-1:0];
    in_win    = 32'(wofs) < WIN_END;
    tx_o      = in_win && (32'(wofs) >= TX_START);
    chan_full = {pair, tx_o};
    hit_o     = in_win && (32'(chan_full) < NCH);
    idx_o     = CIW'(chan_full);
    loff_o    = tx_o ? 5'(wofs - 6'(TX_START)) : wofs[4:0];
  end

  a_r11_tx_is_odd: assert final (!hit_o || (idx_o[0] == tx_o));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int unsigned NCH    = 32,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CIW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    done_pulse,
  output logic              irq,
  output logic              addr32_mode,
  output logic              ch_hit,
  output logic [CIW-1:0]    ch_idx,
  output logic              ch_is_tx,
  output logic [4:0]        ch_loff
);
  import dma_irq_agg_pkg::*;

  reg_sel_e       sel;
  logic [NCH-1:0] stat, en, clr;
  logic           mode_q;
  logic [31:0]    rdata_q;

  always_comb begin
    unique case (32'(bus_addr))
      OFS_ADDRMODE: sel = SEL_MODE;
      OFS_STATUS:   sel = SEL_STAT;
      OFS_PENDING:  sel = SEL_PEND;
      OFS_ENABLE:   sel = SEL_EN;
      default:      sel = SEL_NONE;
    endcase
    clr = (bus_wr && sel == SEL_STAT) ? bus_wdata[NCH-1:0] : '0;
  end

  dma_irq_flag_bank #(.NCH(NCH)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_i   (done_pulse),
    .clr_i   (clr),
    .en_we   (bus_wr && sel == SEL_EN),
    .en_wdata(bus_wdata[NCH-1:0]),
    .stat_o  (stat),
    .en_o    (en),
    .irq_o   (irq)
  );

  dma_irq_chan_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .CIW(CIW)) u_dec (
    .addr_i(bus_addr),
    .hit_o (ch_hit),
    .idx_o (ch_idx),
    .tx_o  (ch_is_tx),
    .loff_o(ch_loff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && sel == SEL_MODE) mode_q <= bus_wdata[0];
      if (bus_rd) begin
        unique case (sel)
          SEL_MODE: rdata_q <= {31'b0, mode_q};
          SEL_STAT: rdata_q <= 32'(stat);
          SEL_PEND: rdata_q <= 32'(stat & en);
          SEL_EN:   rdata_q <= 32'(en);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata   = rdata_q;
  assign addr32_mode = mode_q;

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> (bus_rdata == 32'b0));
  a_r5_pending_view: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_PEND) |=> (bus_rdata == 32'($past(stat) & $past(en))));
  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  a_r8_mode_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_MODE) |=> (bus_rdata[31:1] == 31'b0));
endmodule

// File: tb/dma_irq_agg_tb_top.sv
module dma_irq_agg_tb_top;
  localparam int NCH = 6;
  localparam int AW  = 20;
  localparam int CW  = 3;
  localparam logic [AW-1:0] A_MODE = 20'h00034;
  localparam logic [AW-1:0] A_STAT = 20'h80000;
  localparam logic [AW-1:0] A_PEND = 20'h80004;
  localparam logic [AW-1:0] A_EN   = 20'h80008;
  localparam logic [31:0]   ALLM   = 32'h3F;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] done_pulse = '0;
  logic irq, addr32_mode, ch_hit, ch_is_tx;
  logic [CW-1:0] ch_idx;
  logic [4:0] ch_loff;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_irq_agg #(.NCH(NCH), .ADDR_W(AW), .CIW(CW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .done_pulse(done_pulse), .irq(irq), .addr32_mode(addr32_mode),
    .ch_hit(ch_hit), .ch_idx(ch_idx), .ch_is_tx(ch_is_tx), .ch_loff(ch_loff));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] p);
    @(negedge clk); done_pulse = p;
    @(negedge clk); done_pulse = '0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 mode", {31'b0, addr32_mode}, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_EN, d);   chk("R1 enable", d, 0);

    // R2 set with enable clear, irq stays low
    pulse(6'b000100);
    chk("R2 irq masked", {31'b0, irq}, 0);
    rd(A_STAT, d); chk("R2 status set", d, 32'h4);

    // R5 R6 sweep status x enable
    for (int s = 0; s < 64; s++) begin
      for (int e = 0; e < 64; e += 9) begin
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_EN, e);
        pulse(s[NCH-1:0]);
        chk("R6 irq", {31'b0, irq}, {31'b0, |(s[5:0] & e[5:0])});
        rd(A_PEND, d); chk("R5 pending", d, s & e);
        rd(A_STAT, d); chk("R2 status", d, s);
        rd(A_EN, d);   chk("R7 enable readback", d, e);
      end
    end

    // R3 partial clear
    wr(A_STAT, 32'hFFFF_FFFF);
    pulse(6'b111111);
    wr(A_STAT, 32'h0000_0015);
    rd(A_STAT, d); chk("R3 partial clear", d, 32'h2A);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R3 clear all", d, 0);

    // R4 set wins over clear
    pulse(6'b000011);
    @(negedge clk); bus_addr = A_STAT; bus_wdata = 32'h3; bus_wr = 1; done_pulse = 6'b000001;
    @(negedge clk); bus_wr = 0; done_pulse = '0;
    rd(A_STAT, d); chk("R4 set wins", d, 32'h1);

    // R7 mask keeps status
    wr(A_EN, ALLM);
    chk("R7 irq on", {31'b0, irq}, 1);
    wr(A_EN, 0);
    chk("R7 irq masked", {31'b0, irq}, 0);
    rd(A_STAT, d); chk("R7 status kept", d, 32'h1);

    // R5 write to pending ignored
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_EN, d);   chk("R5 pend write enable", d, 0);
    rd(A_STAT, d); chk("R5 pend write status", d, 32'h1);

    // R8 address mode
    wr(A_MODE, 32'hFFFF_FFFF);
    chk("R8 mode out", {31'b0, addr32_mode}, 1);
    rd(A_MODE, d); chk("R8 mode read", d, 1);
    wr(A_MODE, 32'hFFFF_FFFE);
    rd(A_MODE, d); chk("R8 mode cleared", d, 0);

    // R9 unmapped, R10 hold
    rd(20'h80010, d); chk("R9 unmapped 80010", d, 0);
    rd(20'h00038, d); chk("R9 unmapped 38", d, 0);
    rd(A_STAT, d);
    @(negedge clk); bus_addr = 20'h00000;
    @(negedge clk);
    chk("R10 rdata hold", bus_rdata, 32'h1);

    // R11 decode sweep
    for (int a = 0; a < 4 * 64; a += 4) begin
      int o, ch;
      logic tx, hit;
      o   = a % 64;
      tx  = (o >= 24) && (o < 48);
      ch  = 2 * (a / 64) + (tx ? 1 : 0);
      hit = (o < 48) && (ch < NCH);
      @(negedge clk); bus_addr = AW'(a);
      #1;
      chk("R11 hit", {31'b0, ch_hit}, {31'b0, hit});
      if (hit) begin
        chk("R11 idx", {29'b0, ch_idx}, ch);
        chk("R11 tx", {31'b0, ch_is_tx}, {31'b0, tx});
        chk("R11 loff", {27'b0, ch_loff}, tx ? o - 24 : o);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule